// File: doc/BRIEF.md
# Three-Tap Systolic Convolution Array with Switchable Weight Banks

This block computes a three-tap convolution over a stream of signed samples using a linear chain of three processing cells. A sample is accepted on every cycle where its valid input is high. Each cell multiplies the sample it is given by one of its stored weights. The products are then summed as a partial sum travels from cell to cell. A finished result leaves the last cell on a valid/data output pair, a fixed number of cycles after the sample that completed its window was accepted.

Every cell keeps four weight sets, called banks. A bank select input travels with each sample, so a filter can switch between coefficient sets from one sample to the next without draining or stalling the stream. Weights are written through a simple write port that names a cell, a bank and a value. A synchronous reset empties the pipeline and the window history. It leaves the stored weights untouched.

Each cell keeps its multiplier and its adder in separate register stages. Because of this, one window's multiplication overlaps with an earlier window's accumulation. Window gaps caused by idle input cycles do not break the arithmetic: a window always consists of three consecutive accepted samples.

Top module: `systolic_conv3`

## Requirements
- R1: For accepted samples numbered x(k), x(k+1), x(k+2) in acceptance order, the result produced when x(k+2) is accepted equals W0·x(k) + W1·x(k+1) + W2·x(k+2). Here Wc is the weight of cell c (wrCell value c) in the selected bank.
- R2: Samples and weights are 8-bit two's complement and the result is 20-bit two's complement. Extreme operands such as three products of -128·-128 (49152) and three products of 127·-128 (-48768) are produced exactly.
- R3: After reset, outValid stays low for the first two accepted samples. The third accepted sample, and each one after it, produces exactly one result.
- R4: A result appears (outValid high, outData valid) after the third rising edge following the edge that accepts its completing sample.
- R5: Cycles with inValid low are not samples. They never assert outValid, and they do not split a window: a window spans consecutive accepted samples however many idle cycles lie between them.
- R6: The 2-bit inBank value present with the completing sample selects bank 0..3 for all three weights of that result. inBank may change on every accepted sample.
- R7: A write with wrEn high stores wrData into bank wrBank of cell wrCell (0..2) at the next rising edge. A write that names wrCell = 3 changes no weight.
- R8: A synchronous reset clears outValid at the next edge, discards all in-flight results and restarts the three-sample fill. Weights written before or during reset are kept.
- R9: When a write and a completing sample are presented in the same cycle, that sample's result uses the weight as it was before the write. Samples completing on later edges use the new weight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of pipeline, window and valid state |
| inValid | input | 1 | High when inData holds a sample to accept |
| inData | input | 8 | Signed input sample |
| inBank | input | 2 | Weight bank used for the window this sample completes |
| wrEn | input | 1 | Weight write strobe |
| wrCell | input | 2 | Cell addressed by the write (0..2; 3 ignored) |
| wrBank | input | 2 | Bank addressed by the write |
| wrData | input | 8 | Signed weight value to store |
| outValid | output | 1 | High for one cycle per finished result |
| outData | output | 20 | Signed convolution result |

## Verification
The interesting collision is a weight write aimed at the bank that a completing sample is using in that same cycle. Since the write lands on the same edge that launches the multiplication, a design can easily take the new weight too early or too late. The bench provokes this by rewriting bank 3 on every cycle, rotating through the cells, while samples that select bank 3 stream in back to back. Its reference model computes each expected result from the weights held before that cycle's write and only then applies the write, so a sample that picks up the new weight on the same edge shows up as a data mismatch. A second overlap, reset asserted while samples and writes keep arriving, is judged by checking that no stale result leaves and that later results use the old weights.

// File: rtl/conv_pkg.sv
package conv_pkg;
  // Number of cells in the chain; the control/datapath strobe struct is sized by it.
  localparam int NUM_CELLS = 3;
  localparam int CELL_W    = $clog2(NUM_CELLS + 1);
  localparam int FILL_W    = $clog2(NUM_CELLS);

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic                 shiftEn;  // accept inData into the window history
    logic                 mulEn;    // a window is complete: launch all products
    logic [NUM_CELLS-1:0] addEn;    // per-cell accumulate stage enable
  } ctrl_t;
endpackage

// File: rtl/conv_cell.sv
module conv_cell
  import conv_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ACC_W     = 20,
  parameter int NUM_BANKS = 4,
  parameter int SKEW      = 0,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int PROD_W   = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wrEn,
  input  logic [BANK_W-1:0]        wrBank,
  input  logic signed [DATA_W-1:0] wrData,
  input  logic                     mulEn,
  input  logic [BANK_W-1:0]        mulBank,
  input  logic signed [DATA_W-1:0] sample,
  input  logic                     addEn,
  input  logic signed [ACC_W-1:0]  sumIn,
  output logic signed [ACC_W-1:0]  sumOut
);
  // Weight storage is not reset: it survives a pipeline flush.
  logic signed [DATA_W-1:0] weights [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (wrEn) weights[wrBank] <= wrData;
  end

  // Multiply stage.
  logic signed [PROD_W-1:0] prodReg;
  logic signed [PROD_W-1:0] prodAligned;

  always_ff @(posedge clk) begin
    if (rst)        prodReg <= '0;
    else if (mulEn) prodReg <= weights[mulBank] * sample;
  end

  // Skew the product so it meets the partial sum arriving from upstream cells.
  generate
    if (SKEW == 0) begin : g_noSkew
      assign prodAligned = prodReg;
    end else begin : g_skew
      logic signed [PROD_W-1:0] skewReg [SKEW];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < SKEW; i++) skewReg[i] <= '0;
        end else begin
          skewReg[0] <= prodReg;
          for (int i = 1; i < SKEW; i++) skewReg[i] <= skewReg[i-1];
        end
      end
      assign prodAligned = skewReg[SKEW-1];
    end
  endgenerate

  // Accumulate stage.
  logic signed [ACC_W-1:0] prodExt;
  assign prodExt = {{(ACC_W-PROD_W){prodAligned[PROD_W-1]}}, prodAligned};

  always_ff @(posedge clk) begin
    if (rst)        sumOut <= '0;
    else if (addEn) sumOut <= sumIn + prodExt;
  end
endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  output ctrl_t strobes,
  output logic  outValid
);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(NUM_CELLS - 1);

  logic [FILL_W-1:0]  fillCnt;
  logic [NUM_CELLS:0] validPipe;
  logic               launch;

  // A sample completes a window once enough earlier samples have been accepted.
  assign launch = inValid && (fillCnt == FILL_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt   <= '0;
      validPipe <= '0;
    end else begin
      if (inValid && (fillCnt != FILL_FULL)) fillCnt <= fillCnt + 1'b1;
      validPipe <= {validPipe[NUM_CELLS-1:0], launch};
    end
  end

  always_comb begin
    strobes.shiftEn = inValid;
    strobes.mulEn   = launch;
    strobes.addEn   = validPipe[NUM_CELLS-1:0];
  end

  assign outValid = validPipe[NUM_CELLS];
endmodule

// File: rtl/conv_datapath.sv
module conv_datapath
  import conv_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ACC_W     = 20,
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int HIST_N   = NUM_CELLS - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrl_t                    strobes,
  input  logic signed [DATA_W-1:0] inData,
  input  logic [BANK_W-1:0]        inBank,
  input  logic                     wrEn,
  input  logic [CELL_W-1:0]        wrCell,
  input  logic [BANK_W-1:0]        wrBank,
  input  logic signed [DATA_W-1:0] wrData,
  output logic signed [ACC_W-1:0]  outData
);
  // hist[0] is the newest accepted sample, hist[HIST_N-1] the oldest kept.
  logic signed [DATA_W-1:0] hist [HIST_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST_N; i++) hist[i] <= '0;
    end else if (strobes.shiftEn) begin
      hist[0] <= inData;
      for (int i = 1; i < HIST_N; i++) hist[i] <= hist[i-1];
    end
  end

  logic signed [ACC_W-1:0] sumChain [NUM_CELLS+1];
  assign sumChain[0] = '0;

  generate
    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
      logic signed [DATA_W-1:0] cellSample;
      logic                     cellWr;

      // Cell c sees the sample c positions after the oldest one in the window.
      if (c == NUM_CELLS - 1) begin : g_live
        assign cellSample = inData;
      end else begin : g_hist
        assign cellSample = hist[NUM_CELLS-2-c];
      end

      assign cellWr = wrEn && (wrCell == CELL_W'(c));

      conv_cell #(
        .DATA_W   (DATA_W),
        .ACC_W    (ACC_W),
        .NUM_BANKS(NUM_BANKS),
        .SKEW     (c)
      ) cell_i (
        .clk    (clk),
        .rst    (rst),
        .wrEn   (cellWr),
        .wrBank (wrBank),
        .wrData (wrData),
        .mulEn  (strobes.mulEn),
        .mulBank(inBank),
        .sample (cellSample),
        .addEn  (strobes.addEn[c]),
        .sumIn  (sumChain[c]),
        .sumOut (sumChain[c+1])
      );
    end
  endgenerate

  assign outData = sumChain[NUM_CELLS];
endmodule

// File: rtl/systolic_conv3.sv
module systolic_conv3
  import conv_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ACC_W     = 20,
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  input  logic [BANK_W-1:0]        inBank,
  input  logic                     wrEn,
  input  logic [CELL_W-1:0]        wrCell,
  input  logic [BANK_W-1:0]        wrBank,
  input  logic signed [DATA_W-1:0] wrData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);
  ctrl_t strobes;

  conv_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  conv_datapath #(
    .DATA_W   (DATA_W),
    .ACC_W    (ACC_W),
    .NUM_BANKS(NUM_BANKS)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .inData (inData),
    .inBank (inBank),
    .wrEn   (wrEn),
    .wrCell (wrCell),
    .wrBank (wrBank),
    .wrData (wrData),
    .outData(outData)
  );
endmodule

// File: rtl/conv_chk.sv
module conv_chk #(
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [ACC_W-1:0] outData
);
  logic [2:0] sinceRst;
  logic [1:0] seenCnt;
  logic       winDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
      seenCnt  <= '0;
    end else begin
      if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
      if (inValid && seenCnt != 2'd2) seenCnt <= seenCnt + 2'd1;
    end
  end

  assign winDone = inValid && (seenCnt == 2'd2);

  // R4
  fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 4));

  // R3
  fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(winDone, 4));

  // R5
  window_out_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd4 && $past(winDone, 4)) |-> outValid);

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  // R2
  known_out_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !$isunknown(outData));
endmodule

bind systolic_conv3 conv_chk #(.ACC_W(ACC_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/systolic_conv3_tb_top.sv
`timescale 1ns/1ps
module systolic_conv3_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [7:0]  inData;
  logic [1:0]  inBank;
  logic        wrEn;
  logic [1:0]  wrCell;
  logic [1:0]  wrBank;
  logic [7:0]  wrData;
  logic        outValid;
  logic [19:0] outData;

  always #2 clk = ~clk;  // 250 MHz

  systolic_conv3 dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inBank(inBank),
    .wrEn(wrEn), .wrCell(wrCell), .wrBank(wrBank), .wrData(wrData),
    .outValid(outValid), .outData(outData)
  );

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R8";

  // Behavioural reference state.
  int wm [3][4];
  int histNew = 0, histOld = 0, fill = 0;
  bit expV [4];
  int expD [4];

  function automatic int initWeight(int c, int b);
    case (b)
      0: return c + 1;
      1: return -128;
      2: return 127;
      default: return (c == 0) ? -5 : (c == 1) ? 17 : -33;
    endcase
  endfunction

  task automatic step(input bit v, input int d, input int b, input bit we,
                      input int wc, input int wb, input int wd, input bit r);
    bit newV;
    int newD;
    @(negedge clk);
    // Compare what the design shows now against the prediction made 4 negedges ago.
    compared++;
    if (outValid !== expV[3]) begin
      mismatched++;
      $display("FAIL %s outValid act=%0b exp=%0b t=%0t", curReq, outValid, expV[3], $time);
    end
    if (expV[3]) begin
      compared++;
      if ($signed(outData) !== expD[3]) begin
        mismatched++;
        $display("FAIL %s outData act=%0d exp=%0d t=%0t", curReq, $signed(outData), expD[3], $time);
      end
    end
    // Drive this cycle's inputs.
    rst = r; inValid = v; inData = 8'(d); inBank = 2'(b);
    wrEn = we; wrCell = 2'(wc); wrBank = 2'(wb); wrData = 8'(wd);
    // Reference: result from weights before this cycle's write.
    newV = 1'b0; newD = 0;
    if (r) begin
      for (int i = 0; i < 4; i++) expV[i] = 1'b0;
      fill = 0;
    end else if (v) begin
      if (fill == 2) begin
        newV = 1'b1;
        newD = wm[0][b] * histOld + wm[1][b] * histNew + wm[2][b] * d;
      end
      histOld = histNew;
      histNew = d;
      if (fill < 2) fill++;
    end
    if (we && wc < 3) wm[wc][wb] = wd;
    for (int i = 3; i > 0; i--) begin
      expV[i] = expV[i-1];
      expD[i] = expD[i-1];
    end
    expV[0] = newV;
    expD[0] = newD;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4; i++) begin expV[i] = 1'b0; expD[i] = 0; end
    for (int c = 0; c < 3; c++) for (int b = 0; b < 4; b++) wm[c][b] = 0;
    rst = 1'b1; inValid = 1'b0; inData = '0; inBank = '0;
    wrEn = 1'b0; wrCell = '0; wrBank = '0; wrData = '0;

    // R8: reset state; weights loaded while reset is held.
    curReq = "R8";
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 4; b++)
        step(1, 5, 0, 1, c, b, initWeight(c, b), 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);

    // R3: fill, first two samples give nothing.
    curReq = "R3";
    step(1, 10, 0, 0, 0, 0, 0, 0);
    step(1, -20, 0, 0, 0, 0, 0, 0);
    // R1 / R4: contiguous stream in bank 0.
    curReq = "R1";
    for (int i = 0; i < 18; i++) step(1, ((i * 37) % 256) - 128, 0, 0, 0, 0, 0, 0);
    idle(5);

    // R2: extreme operands.
    curReq = "R2";
    for (int i = 0; i < 5; i++) step(1, -128, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, -128, 2, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, (i % 2 == 0) ? 127 : -128, 2, 0, 0, 0, 0, 0);
    idle(5);

    // R5: gaps between accepted samples.
    curReq = "R5";
    for (int i = 0; i < 60; i++)
      step(($urandom % 3) != 0, int'($urandom % 256) - 128, 0, 0, 0, 0, 0, 0);
    idle(5);

    // R6: bank changes on every sample.
    curReq = "R6";
    for (int i = 0; i < 40; i++)
      step(($urandom % 5) != 0, int'($urandom % 256) - 128, int'($urandom % 4), 0, 0, 0, 0, 0);
    idle(5);

    // R9: writes to the bank in use, in the same cycles as completing samples.
    curReq = "R9";
    for (int i = 0; i < 30; i++)
      step(1, int'($urandom % 256) - 128, 3, 1, i % 3, 3, ((i * 13) % 256) - 128, 0);
    idle(5);

    // R7: writes naming cell 3 change nothing; plain writes land next edge.
    curReq = "R7";
    for (int i = 0; i < 10; i++) step(1, i * 11 - 50, 0, 1, 3, 0, 99, 0);
    step(1, 7, 0, 1, 1, 0, -9, 0);
    for (int i = 0; i < 6; i++) step(1, i * 5 - 12, 0, 0, 0, 0, 0, 0);
    idle(5);

    // R8: reset in mid-stream, weights retained afterwards.
    curReq = "R8";
    for (int i = 0; i < 5; i++) step(1, i * 9 - 20, 3, 0, 0, 0, 0, 0);
    step(1, 33, 3, 0, 0, 0, 0, 1);
    step(1, -33, 3, 0, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) step(1, 40 - i * 8, 3, 0, 0, 0, 0, 0);
    idle(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule